// File: doc/BRIEF.md
# Random Bit Health Monitor and Output Word Bank

The block takes a raw serial bit stream from an entropy source and packs it into a bank of four 32-bit output words. When all four words are full it raises a ready flag and holds them until software acknowledges them. After an acknowledge, a programmable number of idle cycles passes before collection resumes.

While bits arrive, two online health checks run. The first flags a noise failure when the input stays at one level for 48 bits in a row. The second flags a stuck output when a finished word matches the word finished just before it. Each failure event adds to an alarm counter. When the counter goes above a programmable threshold, a sticky shutdown flag is set and the source-run output is dropped. Software reaches the block through a small word-addressed register port that holds the data words, a status/acknowledge register, control, configuration and the threshold. An interrupt line combines the failure flags with per-flag enable bits.

Top module: `rng_health_mon`

## Requirements
- R1: After reset, status (address 4), control (address 5) and configuration (address 6) read 0, the threshold (address 7) reads 0xFF, and irq and src_run are 0.
- R2: Each accepted bit is shifted into a word at its least significant end, so the first bit of a word lands in bit 31. Words fill addresses 0, 1, 2 and 3 in that order. Ready (status bit 0) rises once the 128th bit has been accepted.
- R3: While ready is 1, incoming bits are ignored and the four data words do not change.
- R4: A write to status with bit 0 set clears ready when ready is 1. The next N cycles then discard input bits, where N is configuration bits 7:0.
- R5: While control bit 10 (enable) is 0, no bits are collected and ready reads 0. Clearing enable throws away a partly filled word and restarts filling at address 0.
- R6: 48 consecutive identical accepted input bits set status bit 3 (noise). 47 identical bits do not set it.
- R7: A completed word equal to the previously completed word sets status bit 2 (stuck). This comparison also applies across a disable and enable.
- R8: Every noise or stuck event adds one to an alarm count. When the count exceeds the threshold (address 7, bits 7:0), status bit 1 (shutdown) is set, src_run goes to 0, and collection stops.
- R9: While control bit 8 (test mode) is 1, noise and stuck flags are still set but the alarm count does not change.
- R10: Writing 1 to a status bit among 3..1 clears that bit only, and writing 0 has no effect. Writing 1 to bit 1 also clears the alarm count and restarts the source.
- R11: irq is the OR over status bits 3..1, each ANDed with the control bit at the same position.
- R12: Control reads back bit 10, bit 8 and bits 7:1 and reads 0 elsewhere. Configuration reads back all 32 bits. The threshold reads back bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Raw entropy bit |
| bit_valid | input | 1 | bit_in carries a new bit this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Enabled failure interrupt |
| src_run | output | 1 | Entropy source may run (enabled and not shut down) |

## Verification
The hardest state to reach from the ports is an alarm shutdown caused by stuck words without a noise event mixed in. Every input bit also feeds the run-length check, and constant patterns would trip it first. The stimulus therefore repeats the word 0x0001FFFF, whose longest run is 17 bits, with the threshold set low, so the count crosses the threshold in a known cycle. Test mode is then used to show that the same repeated-word stimulus sets the flag but leaves the count unchanged.

// File: rtl/rng_hm_pkg.sv
package rng_hm_pkg;

    localparam int DATA_W = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADR_STATUS = 3'd4;
    localparam logic [REG_AW-1:0] ADR_CTRL   = 3'd5;
    localparam logic [REG_AW-1:0] ADR_CFG    = 3'd6;
    localparam logic [REG_AW-1:0] ADR_THR    = 3'd7;

    localparam int ST_READY = 0;
    localparam int ST_SHUT  = 1;
    localparam int ST_STUCK = 2;
    localparam int ST_NOISE = 3;

    localparam int CT_EN   = 10;
    localparam int CT_TEST = 8;

    typedef struct packed {
        logic       en;
        logic       test;
        logic [7:1] mask;
    } ctrl_t;

    // order matches status bits 3..1
    typedef struct packed {
        logic noise;
        logic stuck;
        logic shut;
    } flags_t;

endpackage

// File: rtl/rng_run_detect.sv
module rng_run_detect #(
    parameter int RUN_LIMIT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_ok,
    input  logic bit_in,
    output logic evt
);
    localparam int RW = $clog2(RUN_LIMIT + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          last;
        logic          have;
    } run_st_t;

    run_st_t q, d;

    always_comb begin
        d   = q;
        evt = 1'b0;
        if (clr) begin
            d = '0;
        end else if (bit_ok) begin
            if (q.have && (bit_in == q.last)) begin
                if (q.run != RW'(RUN_LIMIT)) d.run = q.run + 1'b1;
                if (q.run == RW'(RUN_LIMIT - 1)) evt = 1'b1;
            end else begin
                d.run = RW'(1);
            end
            d.last = bit_in;
            d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: an event leaves the run counter exactly at the limit
    a_r6_evt_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (q.run == RW'(RUN_LIMIT)));

endmodule

// File: rtl/rng_word_packer.sv
module rng_word_packer #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int REFILL_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    input  logic                                run,
    input  logic                                bit_ok,
    input  logic                                bit_in,
    input  logic                                ack,
    input  logic [REFILL_W-1:0]                 min_refill,
    output logic                                ready_o,
    output logic                                stuck_evt,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    data_o
);
    localparam int BC_W  = $clog2(WORD_W);
    localparam int IDX_W = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] data;
        logic [WORD_W-1:0]                sh;
        logic [WORD_W-1:0]                prev;
        logic                             prev_ok;
        logic [BC_W-1:0]                  bcnt;
        logic [IDX_W-1:0]                 widx;
        logic                             ready;
        logic [REFILL_W-1:0]              gap;
    } pk_st_t;

    pk_st_t q, d;
    logic              take;
    logic [WORD_W-1:0] nsh;

    always_comb begin
        d         = q;
        stuck_evt = 1'b0;
        nsh       = {q.sh[WORD_W-2:0], bit_in};
        take      = en && run && bit_ok && !q.ready && (q.gap == '0);
        if (!en) begin
            d.bcnt  = '0;
            d.widx  = '0;
            d.ready = 1'b0;
            d.gap   = '0;
        end else begin
            if (q.gap != '0) d.gap = q.gap - 1'b1;
            if (ack && q.ready) begin
                d.ready = 1'b0;
                d.gap   = min_refill;
            end
            if (take) begin
                d.sh = nsh;
                if (q.bcnt == BC_W'(WORD_W - 1)) begin
                    d.bcnt         = '0;
                    d.data[q.widx] = nsh;
                    d.prev         = nsh;
                    d.prev_ok      = 1'b1;
                    stuck_evt      = q.prev_ok && (nsh == q.prev);
                    if (q.widx == IDX_W'(NUM_WORDS - 1)) begin
                        d.widx  = '0;
                        d.ready = 1'b1;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o = q.ready;
    assign data_o  = q.data;

    // R3: a full bank is frozen until acknowledged
    a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !ack) |=> $stable(data_o));

    // R5: disabled means not ready
    a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ready_o);

endmodule

// File: rtl/rng_alarm_cnt.sv
module rng_alarm_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [1:0]       evt_n,
    input  logic [CNT_W-1:0] thr,
    output logic             over_o
);
    localparam int QW = CNT_W + 1;
    localparam logic [QW:0] CMAX = {1'b0, {QW{1'b1}}};

    logic [QW-1:0] cnt_q, cnt_d;
    logic [QW:0]   sum;

    always_comb begin
        cnt_d = cnt_q;
        sum   = {1'b0, cnt_q} + {{(QW-1){1'b0}}, evt_n};
        if (clr)                          cnt_d = '0;
        else if (!hold && evt_n != 2'd0)  cnt_d = (sum > CMAX) ? CMAX[QW-1:0] : sum[QW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign over_o = cnt_q > {1'b0, thr};

    // R9: test mode freezes the count
    a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(cnt_q));

    // R10: clearing drops the overflow indication
    a_r10_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !over_o);

endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
    import rng_hm_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int RUN_LIMIT = 48,
    parameter int THR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              src_run
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [REG_AW-1:0] LAST_DATA = REG_AW'(NUM_WORDS - 1);
    localparam logic [THR_W-1:0]  THR_RST   = {THR_W{1'b1}};

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] cfg;
        logic [THR_W-1:0]  thr;
        flags_t            fl;
    } top_st_t;

    top_st_t s_q, s_d;

    logic wr_st, wr_ctrl, wr_cfg, wr_thr;
    logic ack, clr_alarm;
    logic noise_evt, stuck_evt, over, ready;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    assign wr_st     = reg_wr && (reg_addr == ADR_STATUS);
    assign wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_cfg    = reg_wr && (reg_addr == ADR_CFG);
    assign wr_thr    = reg_wr && (reg_addr == ADR_THR);
    assign ack       = wr_st && reg_wdata[ST_READY];
    assign clr_alarm = wr_st && reg_wdata[ST_SHUT];
    assign src_run   = s_q.ctrl.en && !s_q.fl.shut;

    rng_word_packer #(
        .WORD_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .REFILL_W  (8)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (s_q.ctrl.en),
        .run        (src_run),
        .bit_ok     (bit_valid),
        .bit_in     (bit_in),
        .ack        (ack),
        .min_refill (s_q.cfg[7:0]),
        .ready_o    (ready),
        .stuck_evt  (stuck_evt),
        .data_o     (words)
    );

    rng_run_detect #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!s_q.ctrl.en),
        .bit_ok (bit_valid && src_run),
        .bit_in (bit_in),
        .evt    (noise_evt)
    );

    rng_alarm_cnt #(
        .CNT_W (THR_W)
    ) u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_alarm),
        .hold   (s_q.ctrl.test),
        .evt_n  ({1'b0, noise_evt} + {1'b0, stuck_evt}),
        .thr    (s_q.thr),
        .over_o (over)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.ctrl.en   = reg_wdata[CT_EN];
            s_d.ctrl.test = reg_wdata[CT_TEST];
            s_d.ctrl.mask = reg_wdata[7:1];
        end
        if (wr_cfg) s_d.cfg = reg_wdata;
        if (wr_thr) s_d.thr = reg_wdata[THR_W-1:0];
        if (wr_st && reg_wdata[ST_NOISE]) s_d.fl.noise = 1'b0;
        if (wr_st && reg_wdata[ST_STUCK]) s_d.fl.stuck = 1'b0;
        if (noise_evt) s_d.fl.noise = 1'b1;
        if (stuck_evt) s_d.fl.stuck = 1'b1;
        if (clr_alarm) s_d.fl.shut = 1'b0;
        else if (over) s_d.fl.shut = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.thr <= THR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr <= LAST_DATA) begin
            reg_rdata = words[reg_addr[IDX_W-1:0]];
        end else begin
            unique case (reg_addr)
                ADR_STATUS: reg_rdata[3:0] = {s_q.fl, ready};
                ADR_CTRL: begin
                    reg_rdata[CT_EN]   = s_q.ctrl.en;
                    reg_rdata[CT_TEST] = s_q.ctrl.test;
                    reg_rdata[7:1]     = s_q.ctrl.mask;
                end
                ADR_CFG: reg_rdata = s_q.cfg;
                ADR_THR: reg_rdata[THR_W-1:0] = s_q.thr;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq = |(s_q.fl & s_q.ctrl.mask[3:1]);

    // R11: irq only with a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.fl != 3'b000));

    // R8: shutdown stays until software clears it
    a_r8_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fl.shut && !clr_alarm) |=> s_q.fl.shut);

endmodule

// File: tb/rng_health_mon_tb.sv
module rng_health_mon_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, src_run;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rng_health_mon dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .src_run(src_run)
    );

    localparam logic [31:0] EN = 32'h400;
    localparam logic [31:0] TM = 32'h100;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic push(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) push(w[i]);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic chk_words(input string req, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] w3);
        chk_reg(req, 3'd0, w0);
        chk_reg(req, 3'd1, w1);
        chk_reg(req, 3'd2, w2);
        chk_reg(req, 3'd3, w3);
    endtask

    task automatic t_reset();
        chk_reg("R1 status", 3'd4, 32'h0);
        chk_reg("R1 ctrl", 3'd5, 32'h0);
        chk_reg("R1 cfg", 3'd6, 32'h0);
        chk_reg("R1 thr", 3'd7, 32'hFF);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 src_run", {31'd0, src_run}, 32'd0);
    endtask

    task automatic t_disabled();
        for (int i = 0; i < 200; i++) push(i[0]);
        chk_reg("R5 no ready while disabled", 3'd4, 32'h0);
        chk_reg("R5 no data while disabled", 3'd0, 32'h0);
    endtask

    task automatic t_fill();
        wr(3'd5, EN);
        push_word(32'h12345678);
        push_word(32'h9ABCDEF0);
        push_word(32'h0F1E2D3C);
        for (int i = 31; i >= 1; i--) push(1'(32'hC3A55A3C >> i));
        chk_reg("R2 not ready at 127 bits", 3'd4, 32'h0);
        push(1'b0);
        chk_reg("R2 ready at 128 bits", 3'd4, 32'h1);
        chk_words("R2 word order", 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 32'hC3A55A3C);
    endtask

    task automatic t_hold();
        push_word(32'hAAAAAAAA);
        push_word(32'h55555555);
        chk_reg("R3 ready kept", 3'd4, 32'h1);
        chk_words("R3 data frozen", 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 32'hC3A55A3C);
    endtask

    task automatic t_ack_refill();
        wr(3'd6, 32'd4);
        wr(3'd4, 32'h1);
        chk_reg("R4 ack clears ready", 3'd4, 32'h0);
        push(1'b1); push(1'b1); push(1'b0); push(1'b1);
        push_word(32'h0BADF00D);
        push_word(32'h31415926);
        push_word(32'h27182818);
        push_word(32'h55AA33CC);
        chk_reg("R4 refilled", 3'd4, 32'h1);
        chk_words("R4 refill bits dropped", 32'h0BADF00D, 32'h31415926, 32'h27182818, 32'h55AA33CC);
    endtask

    task automatic t_restart();
        wr(3'd4, 32'h1);
        for (int i = 0; i < 10; i++) push(i[0]);
        wr(3'd5, 32'h0);
        chk_reg("R5 disable clears ready", 3'd4, 32'h0);
        check("R5 src_run off", {31'd0, src_run}, 32'd0);
        wr(3'd5, EN);
        push_word(32'h13579BDF);
        push_word(32'h2468ACE0);
        push_word(32'hFEDCBA98);
        push_word(32'h01234567);
        chk_reg("R5 ready after restart", 3'd4, 32'h1);
        chk_words("R5 partial word discarded", 32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98, 32'h01234567);
    endtask

    task automatic t_noise_irq();
        wr(3'd6, 32'd0);
        wr(3'd4, 32'h1);
        for (int i = 0; i < 47; i++) push(1'b0);
        push(1'b1);
        chk_reg("R6 47 equal bits no flag", 3'd4, 32'h0);
        for (int i = 0; i < 47; i++) push(1'b1);
        chk_reg("R6 48 equal bits flag", 3'd4, 32'h8);
        wr(3'd5, EN | 32'h8);
        check("R11 irq enabled", {31'd0, irq}, 32'd1);
        wr(3'd5, EN | 32'h4);
        check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h8);
        chk_reg("R10 noise cleared", 3'd4, 32'h0);
    endtask

    task automatic t_stuck();
        wr(3'd4, 32'h2);
        wr(3'd5, 32'h0);
        wr(3'd5, EN);
        push_word(32'h0001FFFF);
        chk_reg("R7 stuck across restart", 3'd4, 32'h4);
    endtask

    task automatic t_alarm();
        wr(3'd7, 32'd1);
        wr(3'd4, 32'hE);
        chk_reg("R10 all flags cleared", 3'd4, 32'h0);
        push_word(32'h0001FFFF);
        idle();
        chk_reg("R8 one event under threshold", 3'd4, 32'h4);
        check("R8 source still runs", {31'd0, src_run}, 32'd1);
        push_word(32'h0001FFFF);
        idle();
        chk_reg("R8 shutdown above threshold", 3'd4, 32'h6);
        check("R8 source stopped", {31'd0, src_run}, 32'd0);
        push_word(32'h12345678);
        chk_reg("R8 no collection in shutdown", 3'd4, 32'h6);
    endtask

    task automatic t_w1c();
        wr(3'd4, 32'h0);
        chk_reg("R10 zero write no effect", 3'd4, 32'h6);
        wr(3'd4, 32'h2);
        chk_reg("R10 only shutdown cleared", 3'd4, 32'h4);
        check("R10 source restarted", {31'd0, src_run}, 32'd1);
        push_word(32'h12345678);
        chk_reg("R10 collection resumed", 3'd4, 32'h5);
        chk_reg("R10 last word", 3'd3, 32'h12345678);
    endtask

    task automatic t_testmode();
        wr(3'd7, 32'd0);
        wr(3'd4, 32'hF);
        wr(3'd5, EN | TM);
        push_word(32'h3C3C3C3C);
        push_word(32'h3C3C3C3C);
        idle(); idle();
        chk_reg("R9 flag without count", 3'd4, 32'h4);
        check("R9 source runs", {31'd0, src_run}, 32'd1);
        wr(3'd5, EN);
        push_word(32'h3C3C3C3C);
        idle();
        chk_reg("R9 counting resumes", 3'd4, 32'h6);
    endtask

    task automatic t_regs();
        wr(3'd6, 32'hABCD00FF);
        chk_reg("R12 cfg readback", 3'd6, 32'hABCD00FF);
        wr(3'd5, 32'hFFFFFFFF);
        chk_reg("R12 ctrl readback", 3'd5, 32'h000005FE);
        wr(3'd7, 32'h00001234);
        chk_reg("R12 thr readback", 3'd7, 32'h00000034);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fill();
        t_hold();
        t_ack_refill();
        t_restart();
        t_noise_irq();
        t_stuck();
        t_alarm();
        t_w1c();
        t_testmode();
        t_regs();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule